// File: doc/BRIEF.md
# Digital PLL Phase-Domain Detector with Mode-Switched Gain

This block is the phase-detection core of an all-digital frequency synthesizer. It runs on the oscillator clock and keeps a free-running oscillator edge counter. It brings the asynchronous reference clock into that domain through a short synchronizer and detects its rising edge, so every phase comparison happens in a single clock domain. On each detected reference edge it does three things. It advances a fixed-point reference phase accumulator by the frequency command word. It captures the oscillator edge count. It captures the fractional phase code supplied by an external time-to-digital converter.

One cycle later it forms the phase error: the reference phase, minus the captured oscillator count aligned to the binary point, plus the fractional code. This error is a two's-complement value that wraps at the accumulator width. A lock-mode input selects one of three arithmetic right shifts, and the shifted error is registered as the oscillator tuning word. In calibration mode the reference accumulator advances by a fixed parameterized word, so the loop does not depend on the command word there.

Top module: `dpd_core`

## Requirements
- R1: A synchronous reset clears the reference accumulator, the oscillator counter, the synchronizer and the tuning word. The tuning word reads 0 on the cycle after any reset cycle.
- R2: Edges of the oscillator clock are numbered 1, 2, … from the first edge with reset low. If `ref_in` rises between edge m and edge m+1, the comparison captures oscillator count (m+2) mod 2^INT_W. Its tuning word is visible after edge m+4. Exactly one comparison is made per rising edge of `ref_in`.
- R3: The reference accumulator is INT_W+FRAC_W bits wide, with FRAC_W fractional bits. On each comparison it adds the selected increment, modulo 2^(INT_W+FRAC_W). Outside calibration the increment is `fcw`.
- R4: The oscillator counter adds one on every clock edge, modulo 2^INT_W.
- R5: The phase error is computed modulo 2^(INT_W+FRAC_W) and read as two's complement. It is the updated reference phase, minus the captured count shifted left by FRAC_W, plus `tdc_frac`.
- R6: `mode` codes are 0 = calibration, 1 = acquisition, 2 = tracking and 3 = tracking. The tuning word is the phase error arithmetically shifted right by SHIFT_CAL, SHIFT_ACQ or SHIFT_TRK respectively. The mode is taken at the same edge as the phase samples.
- R7: In calibration mode the reference accumulator adds CAL_WORD, and the value on `fcw` has no effect on the tuning word.
- R8: The first comparison after reset updates the accumulators but leaves the tuning word at 0.
- R9: Between comparisons the tuning word holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock |
| fcw | input | INT_W+FRAC_W | Frequency command word, unsigned fixed point |
| tdc_frac | input | FRAC_W | Fractional phase code from the time-to-digital converter |
| mode | input | 2 | Lock mode: 0 calibration, 1 acquisition, 2/3 tracking |
| otw | output | INT_W+FRAC_W | Oscillator tuning word, two's complement |

## Verification
Two wraps can fall in the same comparison. The oscillator counter can roll over in the very cycle it is captured, and the signed error adder can roll over in the same evaluation. The bench provokes this by varying the gap between reference edges so that capture points march across the counter boundary, and by using command words that drive the reference phase past the signed range. Each tuning word is judged against a modulo-width computation done in the bench from the edge index and the accumulated increments, in every mode, including calibration with a changing `fcw`.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    typedef enum logic [1:0] {
        MODE_CAL     = 2'd0,
        MODE_ACQ     = 2'd1,
        MODE_TRK     = 2'd2,
        MODE_TRK_ALT = 2'd3
    } lock_mode_e;

    // Per-comparison control carried from retiming to the datapath
    typedef struct packed {
        logic       sample;  // capture phases this edge
        logic       apply;   // evaluate error / update tuning word
        lock_mode_e mode;    // mode captured with the phases
    } cmp_ctrl_t;

    function automatic int unsigned pick_shift(input lock_mode_e m,
                                               input int unsigned sh_cal,
                                               input int unsigned sh_acq,
                                               input int unsigned sh_trk);
        case (m)
            MODE_CAL: return sh_cal;
            MODE_ACQ: return sh_acq;
            default:  return sh_trk;
        endcase
    endfunction

endpackage

// File: rtl/dpd_retime.sv
module dpd_retime #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic edge_tick
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], ref_in};
    end

    assign edge_tick = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/dpd_ref_accum.sv
module dpd_ref_accum
    import dpd_pkg::*;
#(
    parameter int PW       = 18,
    parameter int CAL_WORD = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  lock_mode_e    mode,
    input  logic [PW-1:0] fcw,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] CAL_INC = PW'(CAL_WORD);

    logic [PW-1:0] step;
    assign step = (mode == MODE_CAL) ? CAL_INC : fcw;

    always_ff @(posedge clk) begin
        if (rst)         phase <= '0;
        else if (sample) phase <= phase + step;
    end
endmodule

// File: rtl/dpd_osc_counter.sv
module dpd_osc_counter #(
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    output logic [IW-1:0] count,
    output logic [IW-1:0] captured
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            captured <= '0;
        end else begin
            count <= count + 1'b1;
            if (sample) captured <= count;
        end
    end
endmodule

// File: rtl/dpd_err_gain.sv
module dpd_err_gain
    import dpd_pkg::*;
#(
    parameter int IW      = 10,
    parameter int FW      = 8,
    parameter int SH_CAL  = 2,
    parameter int SH_ACQ  = 4,
    parameter int SH_TRK  = 6,
    localparam int PW     = IW + FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          apply,
    input  lock_mode_e    mode_q,
    input  logic [PW-1:0] ref_phase,
    input  logic [IW-1:0] osc_phase,
    input  logic [FW-1:0] frac_q,
    output logic [PW-1:0] otw
);
    logic [PW-1:0]        osc_aligned;
    logic [PW-1:0]        err_raw;
    logic signed [PW-1:0] err_s;
    logic signed [PW-1:0] err_scaled;
    int unsigned          sh;
    logic                 armed;

    assign osc_aligned = {osc_phase, {FW{1'b0}}};
    assign err_raw     = ref_phase - osc_aligned + PW'(frac_q);
    assign err_s       = signed'(err_raw);
    assign sh          = pick_shift(mode_q, SH_CAL, SH_ACQ, SH_TRK);
    assign err_scaled  = err_s >>> sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            otw   <= '0;
            armed <= 1'b0;
        end else if (apply) begin
            armed <= 1'b1;
            if (armed) otw <= err_scaled;
        end
    end
endmodule

// File: rtl/dpd_core.sv
module dpd_core
    import dpd_pkg::*;
#(
    parameter int INT_W       = 10,
    parameter int FRAC_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SHIFT_CAL   = 2,
    parameter int SHIFT_ACQ   = 4,
    parameter int SHIFT_TRK   = 6,
    parameter int CAL_WORD    = 51200
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ref_in,
    input  logic [INT_W+FRAC_W-1:0]  fcw,
    input  logic [FRAC_W-1:0]        tdc_frac,
    input  logic [1:0]               mode,
    output logic [INT_W+FRAC_W-1:0]  otw
);
    localparam int PW = INT_W + FRAC_W;

    cmp_ctrl_t         ctrl;
    logic              edge_tick;
    logic [PW-1:0]     ref_phase;
    logic [INT_W-1:0]  osc_count;
    logic [INT_W-1:0]  osc_captured;
    logic [FRAC_W-1:0] frac_q;
    lock_mode_e        mode_live;

    assign mode_live = lock_mode_e'(mode);

    dpd_retime #(.SYNC_STAGES(SYNC_STAGES)) retime_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .edge_tick(edge_tick)
    );

    assign ctrl.sample = edge_tick;

    // capture fraction and mode with the phases; delay strobe to evaluation
    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q     <= '0;
            ctrl.mode  <= MODE_CAL;
            ctrl.apply <= 1'b0;
        end else begin
            ctrl.apply <= ctrl.sample;
            if (ctrl.sample) begin
                frac_q    <= tdc_frac;
                ctrl.mode <= mode_live;
            end
        end
    end

    dpd_ref_accum #(.PW(PW), .CAL_WORD(CAL_WORD)) ref_acc_i (
        .clk(clk), .rst(rst), .sample(ctrl.sample), .mode(mode_live),
        .fcw(fcw), .phase(ref_phase)
    );

    dpd_osc_counter #(.IW(INT_W)) osc_cnt_i (
        .clk(clk), .rst(rst), .sample(ctrl.sample),
        .count(osc_count), .captured(osc_captured)
    );

    dpd_err_gain #(
        .IW(INT_W), .FW(FRAC_W),
        .SH_CAL(SHIFT_CAL), .SH_ACQ(SHIFT_ACQ), .SH_TRK(SHIFT_TRK)
    ) err_gain_i (
        .clk(clk), .rst(rst), .apply(ctrl.apply), .mode_q(ctrl.mode),
        .ref_phase(ref_phase), .osc_phase(osc_captured), .frac_q(frac_q),
        .otw(otw)
    );
endmodule

// File: rtl/dpd_core_chk.sv
module dpd_core_chk #(
    parameter int PW = 18,
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          apply,
    input logic [PW-1:0] ref_phase,
    input logic [IW-1:0] osc_count,
    input logic [PW-1:0] otw
);
    // R1: tuning word cleared after a reset cycle
    a_r1_otw_cleared: assert property (@(posedge clk)
        rst |=> (otw == '0));

    // R2: a reference edge yields a single-cycle strobe
    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R3: reference phase moves only on a comparison
    a_r3_ref_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ref_phase));

    // R4: oscillator counter steps by one each edge
    a_r4_osc_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (osc_count == IW'($past(osc_count) + 1'b1)));

    // R9: tuning word holds when no evaluation is pending
    a_r9_otw_hold: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(otw));
endmodule

bind dpd_core dpd_core_chk #(.PW(PW), .IW(INT_W)) chk_i (
    .clk(clk), .rst(rst), .tick(edge_tick), .apply(ctrl.apply),
    .ref_phase(ref_phase), .osc_count(osc_count), .otw(otw)
);

// File: tb/dpd_core_tb_top.sv
module dpd_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IW   = 6;
    localparam int FW   = 4;
    localparam int PW   = IW + FW;
    localparam int SHC  = 1;
    localparam int SHA  = 2;
    localparam int SHT  = 4;
    localparam int CALW = 165;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_in = 1'b0;
    logic [PW-1:0] fcw = '0;
    logic [FW-1:0] tdc_frac = '0;
    logic [1:0]    mode = 2'd0;
    logic [PW-1:0] otw;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_n   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [PW-1:0] ref_m = '0;
    logic [PW-1:0] exp_otw = '0;
    bit            first = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpd_core #(
        .INT_W(IW), .FRAC_W(FW), .SYNC_STAGES(2),
        .SHIFT_CAL(SHC), .SHIFT_ACQ(SHA), .SHIFT_TRK(SHT), .CAL_WORD(CALW)
    ) dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fcw(fcw),
        .tdc_frac(tdc_frac), .mode(mode), .otw(otw)
    );

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [PW-1:0] act,
                         input logic [PW-1:0] expv);
        n_checks = n_checks + 1;
        if (act !== expv) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: otw=%0h expected %0h", tag, act, expv);
        end
    endtask

    // Called at a negedge; returns at a negedge.
    task automatic run_cycle(input logic [1:0] md, input logic [PW-1:0] w,
                             input logic [FW-1:0] fr, input int gap);
        int m;
        int sh;
        logic [IW-1:0]        smp;
        logic [PW-1:0]        e;
        logic signed [PW-1:0] es;
        string                tag;
        fcw = w; tdc_frac = fr; mode = md; ref_in = 1'b1;
        m = edge_n;
        // R3 / R7: increment choice
        ref_m = ref_m + ((md == 2'd0) ? PW'(CALW) : w);
        // R2 / R4: captured count
        smp = IW'(m + 2);
        // R5: wrapped signed error
        e  = ref_m - {smp, {FW{1'b0}}} + PW'(fr);
        es = signed'(e);
        // R6: shift by mode code
        sh = (md == 2'd0) ? SHC : (md == 2'd1) ? SHA : SHT;
        if (first) tag = "R8 first comparison suppressed";
        else if (md == 2'd0) tag = "R7 calibration ignores fcw";
        else tag = "R2/R5/R6 tuning word";
        if (!first) exp_otw = PW'(es >>> sh);
        first = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tag, otw, exp_otw);
        ref_in = 1'b0;
        repeat (3 + gap) @(posedge clk);
        @(negedge clk);
        check("R9 hold between comparisons", otw, exp_otw);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset value", otw, '0);
        rst = 1'b0;
        for (int md = 0; md < 4; md++) begin
            for (int i = 0; i < 8; i++) begin
                for (int f = 0; f < 16; f++) begin
                    run_cycle(2'(md), PW'(i * 137 + f * 53 + 29), FW'(f),
                              (i + f + md) % 5);
                end
            end
        end
        // mid-run reset
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset after activity", otw, '0);
        rst = 1'b0;
        ref_m = '0; exp_otw = '0; first = 1'b1;
        for (int k = 0; k < 12; k++) begin
            run_cycle(2'(k % 3 + 1), PW'(k * 311 + 7), FW'(k), k % 4);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule